// File: doc/BRIEF.md
# Ordered Dial Combination Lock

This block is a clocked state machine that models a rotary-dial combination lock. Each cycle it may accept one dial operation, given by a valid strobe, a direction bit (turn right or turn left) and a dial position from 0 to 39. The lock releases only when three operations arrive in one fixed order: right to 13, then left to 22, then right to 3. The same three values in any other order do not open it.

Progress is held in two state flip-flops and is shown on a state output. The open output follows the state. Once open, the lock ignores further operations. It closes again only on a relock pulse or a synchronous reset. A wrong operation discards partial progress. The one exception is a wrong operation that is itself the first step of the combination, which counts as a fresh start.

Top module: `dial_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 2'b00 and `unlocked` is low after that edge.
- R2: The `lock_state` output uses this encoding: 2'b00 idle, 2'b01 first step done, 2'b10 two steps done, 2'b11 open.
- R3: The operations right-13, left-22 and right-3 (`op_left` is 0 for right and 1 for left), each on its own valid cycle, move the state 00→01→10→11. Each move is visible after the edge that samples that operation.
- R4: `unlocked` is high exactly when the state is 2'b11.
- R5: In states 00, 01 or 10, a valid operation that is not the expected next step and is not right-13 returns the state to 2'b00.
- R6: In states 00, 01 or 10, a valid right-13 that is not the expected next step moves the state to 2'b01.
- R7: A cycle with `op_valid` low leaves the state unchanged, whatever `op_left` and `op_num` carry.
- R8: In state 2'b11, valid operations have no effect, and the lock stays open.
- R9: In state 2'b11, `relock` high at an edge moves the state to 2'b00. In the other states, `relock` has no effect.
- R10: A dial number above 39 never matches a step. A valid operation carrying such a number returns states 00, 01 and 10 to 2'b00.
- R11: Reset takes priority over `op_valid` and `relock` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: an operation is present this cycle |
| op_left | input | 1 | Direction: 0 right, 1 left |
| op_num | input | 6 | Dial position, 0 to 39 legal |
| relock | input | 1 | Closes the open lock |
| unlocked | output | 1 | High while the lock is open |
| lock_state | output | 2 | Current sequence state |

## Verification
Every result is due one rising edge after its stimulus. The edge that samples an operation, a relock or a reset updates the state register. `unlocked` is decoded from that register, so it changes after the same edge. The bench drives inputs on the falling edge and compares outputs on the next falling edge, which is half a cycle after the edge that acted on them. Hold cases idle the strobe for several cycles and compare each one.

// File: rtl/dial_lock_pkg.sv
package dial_lock_pkg;
  localparam int NUM_W     = 6;
  localparam int DIAL_LAST = 39;
  localparam int N_STEPS   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_OPEN = 2'b11
  } lock_state_e;

  typedef struct packed {
    logic             left;
    logic [NUM_W-1:0] num;
  } dial_op_t;

  // Direction demanded by combination step idx (1 = left)
  function automatic logic step_left(int idx);
    case (idx)
      1:       return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Dial position demanded by combination step idx
  function automatic logic [NUM_W-1:0] step_num(int idx);
    case (idx)
      0:       return NUM_W'(13);
      1:       return NUM_W'(22);
      default: return NUM_W'(3);
    endcase
  endfunction

  function automatic logic in_dial(logic [NUM_W-1:0] n);
    return n <= NUM_W'(DIAL_LAST);
  endfunction

  // State reached after completing the step expected in s
  function automatic lock_state_e advance(lock_state_e s);
    case (s)
      ST_IDLE: return ST_ONE;
      ST_ONE:  return ST_TWO;
      default: return ST_OPEN;
    endcase
  endfunction
endpackage

// File: rtl/dial_op_check.sv
module dial_op_check
  import dial_lock_pkg::*;
(
  input  dial_op_t           op,
  output logic               in_range,
  output logic [N_STEPS-1:0] step_hit
);
  assign in_range = in_dial(op.num);

  for (genvar g = 0; g < N_STEPS; g++) begin : g_step
    assign step_hit[g] = in_range && (op.left == step_left(g)) && (op.num == step_num(g));
  end
endmodule

// File: rtl/dial_lock_fsm.sv
module dial_lock_fsm
  import dial_lock_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic               relock,
  input  logic [N_STEPS-1:0] step_hit,
  output lock_state_e        state_q
);
  lock_state_e nxt;
  logic        exp_hit;     // operation is the step expected now
  logic        restart_hit; // operation is the first step

  always_comb begin
    case (state_q)
      ST_IDLE: exp_hit = step_hit[0];
      ST_ONE:  exp_hit = step_hit[1];
      ST_TWO:  exp_hit = step_hit[2];
      default: exp_hit = 1'b0;
    endcase
  end
  assign restart_hit = step_hit[0];

  always_comb begin
    nxt = state_q;
    if (state_q == ST_OPEN) begin
      if (relock) nxt = ST_IDLE;
    end else if (op_valid) begin
      if (exp_hit)          nxt = advance(state_q);
      else if (restart_hit) nxt = ST_ONE;
      else                  nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= nxt;
  end

  p_hold_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && state_q != ST_OPEN) |=> $stable(state_q));
  p_open_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN && !relock) |=> state_q == ST_OPEN);
  p_relock_close_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN && relock) |=> state_q == ST_IDLE);
  p_relock_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_OPEN && !op_valid && relock) |=> $stable(state_q));
  p_wrong_op_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && state_q != ST_OPEN && !exp_hit && !restart_hit) |=> state_q == ST_IDLE);
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && state_q != ST_OPEN && !exp_hit && restart_hit) |=> state_q == ST_ONE);
endmodule

// File: rtl/dial_lock.sv
module dial_lock
  import dial_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_left,
  input  logic [NUM_W-1:0] op_num,
  input  logic             relock,
  output logic             unlocked,
  output logic [1:0]       lock_state
);
  dial_op_t           op;
  logic               in_range;
  logic [N_STEPS-1:0] step_hit;
  lock_state_e        state_q;

  assign op = '{left: op_left, num: op_num};

  dial_op_check u_check (
    .op       (op),
    .in_range (in_range),
    .step_hit (step_hit)
  );

  dial_lock_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .relock   (relock),
    .step_hit (step_hit),
    .state_q  (state_q)
  );

  assign lock_state = state_q;
  assign unlocked   = (state_q == ST_OPEN);

  p_open_via_last_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(op_valid && !op_left && op_num == NUM_W'(3)));
  p_out_of_range_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !in_range && state_q != ST_OPEN) |=> lock_state == 2'b00);
endmodule

// File: tb/dial_lock_tb.sv
module dial_lock_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic       op_left = 1'b0;
  logic [5:0] op_num = '0;
  logic       relock = 1'b0;
  logic       unlocked;
  logic [1:0] lock_state;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dial_lock u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_left(op_left),
    .op_num(op_num), .relock(relock), .unlocked(unlocked), .lock_state(lock_state)
  );

  task automatic chk(string tag, logic [1:0] exp_st);
    logic exp_open;
    exp_open = (exp_st == 2'b11);
    n_run++;
    if (lock_state !== exp_st || unlocked !== exp_open) begin
      n_fail++;
      $display("FAIL %s: state=%b unlocked=%b expected state=%b unlocked=%b",
               tag, lock_state, unlocked, exp_st, exp_open);
    end
  endtask

  // one operation, sampled on the next rising edge, checked at the falling edge after it
  task automatic op(logic l, logic [5:0] n);
    @(negedge clk);
    op_valid = 1'b1; op_left = l; op_num = n;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic pulse_relock();
    @(negedge clk); relock = 1'b1;
    @(negedge clk); relock = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic open_lock();
    op(1'b0, 6'd13); op(1'b1, 6'd22); op(1'b0, 6'd3);
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    chk("R1 reset state", 2'b00);
    rst = 1'b0;
  endtask

  task automatic t_sequence();
    do_reset();
    op(1'b0, 6'd13); chk("R3 R2 step one", 2'b01);
    op(1'b1, 6'd22); chk("R3 R2 step two", 2'b10);
    op(1'b0, 6'd3);  chk("R3 R4 open", 2'b11);
  endtask

  task automatic t_open_hold();
    do_reset(); open_lock();
    op(1'b0, 6'd13); chk("R8 op in open", 2'b11);
    op(1'b1, 6'd50); chk("R8 bad op in open", 2'b11);
    pulse_relock();  chk("R9 relock closes", 2'b00);
  endtask

  task automatic t_relock_ignored();
    do_reset(); op(1'b0, 6'd13);
    pulse_relock(); chk("R9 relock in step one", 2'b01);
  endtask

  task automatic t_no_strobe();
    do_reset(); op(1'b0, 6'd13); op(1'b1, 6'd22);
    @(negedge clk); op_left = 1'b0; op_num = 6'd3;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R7 strobe low hold", 2'b10);
    end
  endtask

  task automatic t_wrong();
    do_reset(); op(1'b0, 6'd13);
    op(1'b1, 6'd13); chk("R5 wrong dir in one", 2'b00);
    op(1'b0, 6'd13); op(1'b1, 6'd22);
    op(1'b0, 6'd22); chk("R5 wrong op in two", 2'b00);
    op(1'b1, 6'd22); chk("R5 order matters in idle", 2'b00);
  endtask

  task automatic t_restart();
    do_reset(); op(1'b0, 6'd13); op(1'b1, 6'd22);
    op(1'b0, 6'd13); chk("R6 restart from two", 2'b01);
    op(1'b0, 6'd13); chk("R6 restart from one", 2'b01);
  endtask

  task automatic t_range();
    do_reset();
    op(1'b0, 6'd53); chk("R10 out of range idle", 2'b00);
    op(1'b0, 6'd13); op(1'b1, 6'd62); chk("R10 out of range one", 2'b00);
  endtask

  task automatic t_reset_priority();
    do_reset();
    @(negedge clk); rst = 1'b1; op_valid = 1'b1; op_left = 1'b0; op_num = 6'd13;
    @(negedge clk); rst = 1'b0; op_valid = 1'b0;
    chk("R11 reset beats op", 2'b00);
    open_lock();
    @(negedge clk); rst = 1'b1; relock = 1'b1;
    @(negedge clk); rst = 1'b0; relock = 1'b0;
    chk("R11 reset in open", 2'b00);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_open_hold();
    t_relock_ignored();
    t_no_strobe();
    t_wrong();
    t_restart();
    t_range();
    t_reset_priority();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finish_run();
    end
  end
endmodule